// File: doc/BRIEF.md
# Register-File LIFO Stack with Occupancy Flags

This block is a last-in, first-out store held entirely in flip-flops. A pointer register of `AW` bits (six by default, giving 64 words) selects the current top of stack. Two flag registers report whether the stack is empty or completely full. The block keeps no separate occupancy counter. Both flags are derived from the pointer wrapping through zero.

Each clock accepts at most one operation. A push advances the pointer first and then stores the input word at the new pointer position. A pop first copies the word at the current pointer into an output data register and then moves the pointer back. Requests that cannot be honoured are dropped and flagged by a single-cycle error pulse: a push while full, a pop while empty, or a push and a pop in the same cycle. The output data register keeps its value until the next accepted pop.

A consequence of the wrap rule is that the first push after reset writes slot 1, and the 64th push writes slot 0. Slot 0 therefore holds the newest word whenever the stack is full.

Top module: `lifo_regstack`

## Requirements
- R1: After reset, the pointer reads 0, the empty flag is 1, the full flag is 0, the data output is 0, and all three error pulses are 0.
- R2: An accepted push increments the pointer modulo 2**AW. It stores the input word in the slot addressed by the incremented pointer. The new pointer is visible on the clock after the request.
- R3: An accepted push sets the full flag when the incremented pointer equals 0, and clears the empty flag whenever it is accepted.
- R4: An accepted pop loads the word stored at the current pointer into the data output on the clock after the request, and decrements the pointer modulo 2**AW.
- R5: An accepted pop sets the empty flag when the decremented pointer equals 0, and clears the full flag whenever it is accepted.
- R6: A push request with pop low while full is 1 is ignored: the pointer, the flags and the stored words stay unchanged. The overflow output is 1 for exactly the following cycle.
- R7: A pop request with push low while empty is 1 is ignored: the pointer, the flags and the data output stay unchanged. The underflow output is 1 for exactly the following cycle.
- R8: When push and pop are both requested in one cycle, both are ignored regardless of the flags. The conflict output is 1 for the following cycle, and overflow and underflow stay 0.
- R9: The data output changes only on the clock after an accepted pop and otherwise holds its value.
- R10: The full and empty flags are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| din_i | input | W | Word to store on a push |
| dout_o | output | W | Data register, loaded by an accepted pop |
| sp_o | output | AW | Current stack pointer |
| full_o | output | 1 | All 2**AW slots are occupied |
| empty_o | output | 1 | No slot is occupied |
| ovf_o | output | 1 | One-cycle pulse: push refused because the stack was full |
| unf_o | output | 1 | One-cycle pulse: pop refused because the stack was empty |
| clash_o | output | 1 | One-cycle pulse: push and pop were requested together |

## Verification
The stack is first exercised with short push-then-pop bursts, which confirm the LIFO order and the off-by-one slot addressing. A complete fill to 64 words followed by a complete drain then drives the pointer through zero in both directions. This shows that the flags follow the wrap and do not follow a count, and that slot 0 holds the newest word when the stack is full. Refused requests are applied at both extremes and together, which separates dropped operations from partially applied ones. A long pseudo-random mix of push, pop, idle and conflicting cycles, compared cycle by cycle against a queue model, covers interleavings that the directed patterns miss.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_PUSH  = 2'd1,
        ACT_POP   = 2'd2,
        ACT_CLASH = 2'd3
    } lifo_act_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic clash;
    } lifo_err_t;

endpackage

// File: rtl/lifo_req_decode.sv
module lifo_req_decode
    import lifo_pkg::*;
(
    input  logic      push_i,
    input  logic      pop_i,
    input  logic      full_i,
    input  logic      empty_i,
    output lifo_act_e act_o,
    output lifo_err_t err_o
);

    always_comb begin
        act_o = ACT_HOLD;
        err_o = '0;
        if (push_i && pop_i) begin
            act_o       = ACT_CLASH;
            err_o.clash = 1'b1;
        end else if (push_i) begin
            if (full_i) begin
                err_o.ovf = 1'b1;
            end else begin
                act_o = ACT_PUSH;
            end
        end else if (pop_i) begin
            if (empty_i) begin
                err_o.unf = 1'b1;
            end else begin
                act_o = ACT_POP;
            end
        end
    end

endmodule

// File: rtl/lifo_ptr_ctrl.sv
module lifo_ptr_ctrl
    import lifo_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lifo_act_e     act_i,
    input  lifo_err_t     err_i,
    output logic [AW-1:0] sp_o,
    output logic [AW-1:0] sp_inc_o,
    output logic          full_o,
    output logic          empty_o,
    output lifo_err_t     err_o
);

    localparam logic [AW-1:0] SP_ZERO = '0;
    localparam logic [AW-1:0] SP_ONE  = AW'(1);

    typedef struct packed {
        logic [AW-1:0] sp;
        logic          full;
        logic          empty;
        lifo_err_t     err;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [AW-1:0] sp_inc, sp_dec;

    assign sp_inc = st_q.sp + SP_ONE;
    assign sp_dec = st_q.sp - SP_ONE;

    always_comb begin
        st_d     = st_q;
        st_d.err = err_i;
        unique case (act_i)
            ACT_PUSH: begin
                st_d.sp    = sp_inc;
                st_d.empty = 1'b0;
                st_d.full  = (sp_inc == SP_ZERO);
            end
            ACT_POP: begin
                st_d.sp    = sp_dec;
                st_d.full  = 1'b0;
                st_d.empty = (sp_dec == SP_ZERO);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sp    <= SP_ZERO;
            st_q.full  <= 1'b0;
            st_q.empty <= 1'b1;
            st_q.err   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sp_o     = st_q.sp;
    assign sp_inc_o = sp_inc;
    assign full_o   = st_q.full;
    assign empty_o  = st_q.empty;
    assign err_o    = st_q.err;

endmodule

// File: rtl/lifo_storage.sv
module lifo_storage #(
    parameter int W  = 16,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [W-1:0]  rd_data_o
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic          sel;
        logic [W-1:0]  slot_d;

        assign sel = wr_en_i && (wr_addr_i == AW'(g));

        always_comb begin
            slot_d = slot_q[g];
            if (sel) begin
                slot_d = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d;
            end
        end
    end

    assign rd_data_o = slot_q[rd_addr_i];

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
    import lifo_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [W-1:0]  din_i,
    output logic [W-1:0]  dout_o,
    output logic [AW-1:0] sp_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic          clash_o
);

    typedef struct packed {
        logic [W-1:0] dr;
    } dr_state_t;

    lifo_act_e     act;
    lifo_err_t     err_now, err_q;
    logic [AW-1:0] sp, sp_inc;
    logic          full, empty;
    logic [W-1:0]  top_word;
    dr_state_t     dr_d, dr_q;

    lifo_req_decode u_dec (
        .push_i  (push_i),
        .pop_i   (pop_i),
        .full_i  (full),
        .empty_i (empty),
        .act_o   (act),
        .err_o   (err_now)
    );

    lifo_ptr_ctrl #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (act),
        .err_i    (err_now),
        .sp_o     (sp),
        .sp_inc_o (sp_inc),
        .full_o   (full),
        .empty_o  (empty),
        .err_o    (err_q)
    );

    lifo_storage #(.W(W), .AW(AW)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (act == ACT_PUSH),
        .wr_addr_i (sp_inc),
        .wr_data_i (din_i),
        .rd_addr_i (sp),
        .rd_data_o (top_word)
    );

    always_comb begin
        dr_d = dr_q;
        if (act == ACT_POP) begin
            dr_d.dr = top_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q <= '0;
        end else begin
            dr_q <= dr_d;
        end
    end

    assign dout_o  = dr_q.dr;
    assign sp_o    = sp;
    assign full_o  = full;
    assign empty_o = empty;
    assign ovf_o   = err_q.ovf;
    assign unf_o   = err_q.unf;
    assign clash_o = err_q.clash;

endmodule

// File: rtl/lifo_regstack_chk.sv
module lifo_regstack_chk #(
    parameter int W  = 16,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic [W-1:0]  dout_o,
    input logic [AW-1:0] sp_o,
    input logic          full_o,
    input logic          empty_o,
    input logic          ovf_o,
    input logic          unf_o,
    input logic          clash_o
);

    localparam logic [AW-1:0] SP_TOP = '1;
    localparam logic [AW-1:0] SP_ONE = AW'(1);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o)); // R10

    AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (sp_o == $past(sp_o) + SP_ONE) && !empty_o); // R2

    AST_FULL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o && sp_o == SP_TOP) |=> full_o); // R3

    AST_POP_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (sp_o == $past(sp_o) - SP_ONE) && !full_o); // R4

    AST_EMPTY_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o && sp_o == SP_ONE) |=> empty_o); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> ovf_o && full_o && $stable(sp_o)); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> unf_o && empty_o && $stable(sp_o) && $stable(dout_o)); // R7

    AST_CLASH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> clash_o && !ovf_o && !unf_o && $stable(sp_o)); // R8

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && !push_i && !empty_o) |=> $stable(dout_o)); // R9

endmodule

bind lifo_regstack lifo_regstack_chk #(.W(W), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .dout_o  (dout_o),
    .sp_o    (sp_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o),
    .clash_o (clash_o)
);

// File: tb/tb_lifo_regstack.sv
`timescale 1ns/1ps
module tb_lifo_regstack;

    localparam int W     = 16;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [W-1:0]  din_i = '0;
    logic [W-1:0]  dout_o;
    logic [AW-1:0] sp_o;
    logic          full_o, empty_o, ovf_o, unf_o, clash_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // behavioural model: a queue of stored words plus the last popped word
    logic [W-1:0] q_m[$];
    logic [W-1:0] dout_m;
    bit ovf_m, unf_m, clash_m;
    int seed = 32'h1234_5678;

    always #2 clk = ~clk;

    lifo_regstack #(.W(W), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .din_i(din_i),
        .dout_o(dout_o), .sp_o(sp_o), .full_o(full_o), .empty_o(empty_o),
        .ovf_o(ovf_o), .unf_o(unf_o), .clash_o(clash_o)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int n;
        n = q_m.size();
        tests++;
        cmp(tag, "sp", int'(sp_o), n % DEPTH);
        cmp(tag, "full", int'(full_o), int'(n == DEPTH));
        cmp(tag, "empty", int'(empty_o), int'(n == 0));
        cmp(tag, "dout", int'(dout_o), int'(dout_m));
        cmp(tag, "ovf", int'(ovf_o), int'(ovf_m));
        cmp(tag, "unf", int'(unf_o), int'(unf_m));
        cmp(tag, "clash", int'(clash_o), int'(clash_m));
    endtask

    // drive one cycle of requests, advance the model at the edge, compare 1 ns later
    task automatic step(input bit ps, input bit pp, input logic [W-1:0] d, input string tag);
        push_i = ps;
        pop_i  = pp;
        din_i  = d;
        @(posedge clk);
        ovf_m = 0; unf_m = 0; clash_m = 0;
        if (ps && pp) clash_m = 1;
        else if (ps) begin
            if (q_m.size() == DEPTH) ovf_m = 1;
            else q_m.push_back(d);
        end else if (pp) begin
            if (q_m.size() == 0) unf_m = 1;
            else dout_m = q_m.pop_back();
        end
        #1;
        check_all(tag);
    endtask

    function automatic logic [W-1:0] nxt();
        seed = seed * 1103515245 + 12345;
        return W'(seed >>> 8);
    endfunction

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    fails++;
                    tests++;
                    $display("FAIL watchdog actual=timeout expected=finish");
                    $display("[TB] %0d tests run, %0d failed", tests, fails);
                    $finish;
                end
            end
        join_none

        dout_m = '0; ovf_m = 0; unf_m = 0; clash_m = 0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        rst_n = 1'b1;
        #1;
        check_all("R1");

        // short burst: LIFO order and slot addressing
        step(1, 0, 16'hA001, "R2");
        step(1, 0, 16'hA002, "R2");
        step(1, 0, 16'hA003, "R2");
        step(0, 0, 16'h0, "R9");
        step(0, 1, 16'h0, "R4");
        step(0, 0, 16'h0, "R9");
        step(0, 1, 16'h0, "R4");
        step(0, 1, 16'h0, "R5");
        // refused pop on empty
        step(0, 1, 16'h0, "R7");
        step(0, 0, 16'h0, "R7");
        step(0, 1, 16'h0, "R7");
        // conflicting requests while empty and while holding data
        step(1, 1, 16'hBEEF, "R8");
        step(0, 0, 16'h0, "R8");
        step(1, 0, 16'h5A5A, "R2");
        step(1, 1, 16'hCAFE, "R8");
        step(0, 1, 16'h0, "R8");

        // full fill through the wrap
        for (int i = 0; i < DEPTH; i++) step(1, 0, W'(16'h1000 + i), "R3");
        step(1, 0, 16'hDEAD, "R6");
        step(0, 0, 16'h0, "R6");
        step(1, 0, 16'hDEAD, "R6");
        step(1, 1, 16'hDEAD, "R8");
        step(0, 1, 16'h0, "R5");
        step(1, 0, 16'h2222, "R3");
        // full drain back through zero
        for (int i = 0; i < DEPTH; i++) step(0, 1, 16'h0, "R5");
        step(0, 1, 16'h0, "R7");
        step(0, 0, 16'h0, "R9");

        // random mix of push, pop, idle and conflict cycles
        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] r;
            r = nxt();
            case (r[2:0])
                3'd0, 3'd1, 3'd2: step(1, 0, nxt(), "R2");
                3'd3, 3'd4:       step(0, 1, 16'h0, "R4");
                3'd5:             step(1, 1, nxt(), "R8");
                default:          step(0, 0, 16'h0, "R9");
            endcase
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule